// File: doc/BRIEF.md
# I2C Register-Access Transaction Sequencer

This block turns one request into a complete register-addressed bus transaction: a presence probe, a read of N bytes or a write of N bytes. It sits above a bit-phase engine that handles the wire timing. The sequencer issues START, STOP, byte-write and byte-read commands to that engine in the correct order. It waits for each command to complete before it issues the next one. Each request carries a 7-bit device address, a register address of zero to four bytes and a byte count.

Write data comes in on a valid/ready stream and read data goes out on another. When the data stream is not ready, the sequencer simply withholds the next bus command, so the bus is stretched rather than corrupted. Two per-request options shape the transaction. The first chooses the turnaround before the read phase: a repeated START, or a STOP then a START. The second is a mask that moves register-address bits above the transmitted bytes into the low device-address bits, so that a large memory answers as a group of smaller devices. Every transaction ends with a one-cycle completion pulse and a status code.

Top module: `i2c_txn_seq`

## Requirements
- R1: A probe (reqOp=0) issues START, then a write of {device,0}, then STOP. The status is 0 (ok) if the engine acknowledged that byte and 1 (no device) if it did not.
- R2: A read (reqOp=1) or write (reqOp=2) with address length L>0 issues START, then {device,0}, then the L low bytes of reqAddr, most significant byte first. L may be any value from 1 to 4.
- R3: If {device,0} of a read or write is not acknowledged, the sequencer issues STOP next and reports status 1.
- R4: If a register-address byte is not acknowledged, the sequencer issues no further byte commands, issues STOP and reports status 2 (address error).
- R5: After the address phase of a read, cfgRepStart=1 issues a single START. cfgRepStart=0 issues STOP and then START.
- R6: A read with L=0 issues START followed directly by {device,1}, with no address-phase commands.
- R7: The read phase issues {device,1} and then N byte reads. Every read carries cmdNackOut=0 except the last, which carries 1. STOP follows. The received bytes appear on rdData in order. The acknowledge of {device,1} has no effect on the sequence.
- R8: On a write, a data byte that is not acknowledged does not stop the transfer. nackCount reports the number of such bytes. The status is 3 when that count is nonzero and 0 otherwise.
- R9: The device address used is reqDev OR ((reqAddr >> 8L) AND cfgOvfMask), taken over the low 7 bits.
- R10: While rdData waits for rdReady, or the sequencer waits for wrValid, cmdValid stays low. A command, once raised, holds its op and data until engDone.
- R11: reqReady is high only when the block is idle. A request presented while the block is busy is ignored. done is high for exactly one cycle per transaction, together with statusCode and nackCount.
- R12: After reset: reqReady=1, and cmdValid, done, rdValid and wrReady are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request accepted |
| reqOp | input | 2 | 0 probe, 1 read, 2 write |
| reqDev | input | 7 | Device address |
| reqAddr | input | 32 | Register address, low L bytes used |
| reqAlen | input | 3 | Register address length L, 0..4 |
| reqLen | input | 8 | Data byte count N |
| cfgRepStart | input | 1 | 1: repeated START turnaround, 0: STOP then START |
| cfgOvfMask | input | 7 | Mask of address-overflow bits folded into device address |
| wrData | input | 8 | Write data stream byte |
| wrValid | input | 1 | Write data valid |
| wrReady | output | 1 | Write data taken |
| rdData | output | 8 | Read data stream byte |
| rdValid | output | 1 | Read data valid |
| rdReady | input | 1 | Read data consumer ready |
| cmdValid | output | 1 | Command to engine pending |
| cmdOp | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmdData | output | 8 | Byte to write |
| cmdNackOut | output | 1 | For read byte: 1 sends not-acknowledge |
| engDone | input | 1 | Engine finished the pending command |
| engNack | input | 1 | Written byte was not acknowledged |
| engRxData | input | 8 | Byte read by engine |
| done | output | 1 | Transaction complete pulse |
| statusCode | output | 2 | 0 ok, 1 no device, 2 address error, 3 data nacks |
| nackCount | output | 8 | Count of unacknowledged write data bytes |

## Verification
Transactions are driven against a behavioural engine. This engine acknowledges a window of four device addresses and rejects one reserved address value and any byte whose top nibble is all ones. The full command sequence it records is compared with one rebuilt from the request.

The stimulus covers the following cases:
- Probes of present and absent devices, which separate the ok and no-device outcomes.
- Reads with each turnaround setting and with L of 0, 1 and 2, which show whether the address phase is skipped and which turnaround was taken.
- Writes with L of 0 to 4, with and without rejected data bytes, which separate the abort-on-address rule from the count-and-continue rule for data.
- A masked overflow address and a device that rejects only the read-direction byte, which expose the address fold and show that the read-direction acknowledge is ignored.

Directed cases hold back each stream to expose the stall, and offer a request while the block is busy.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } reqop_e;

  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WRITE = 2'd2,
    BC_READ  = 2'd3
  } buscmd_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NODEV    = 2'd1,
    ST_ADDRERR  = 2'd2,
    ST_DATANACK = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    SEL_DEVW = 2'd0,
    SEL_DEVR = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_DATA = 2'd3
  } bytesel_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic     latchReq;
    logic     shiftAddr;
    logic     loadWr;
    logic     loadRd;
    logic     decLen;
    logic     incNack;
    logic     setErr;
    status_e  errCode;
    bytesel_e sel;
  } ctl_t;

endpackage

// File: rtl/i2c_txn_dp.sv
module i2c_txn_dp
  import i2c_txn_pkg::*;
#(
  parameter int DEV_W      = 7,
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  parameter int ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic [1:0]              reqOp,
  input  logic [DEV_W-1:0]        reqDev,
  input  logic [8*ADDR_BYTES-1:0] reqAddr,
  input  logic [ALEN_W-1:0]       reqAlen,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic                    cfgRepStart,
  input  logic [DEV_W-1:0]        cfgOvfMask,
  input  logic [7:0]              wrData,
  input  logic [7:0]              engRxData,
  output reqop_e                  opReg,
  output logic                    repReg,
  output logic                    alenZero,
  output logic                    alenLast,
  output logic                    lenZero,
  output logic                    lenLast,
  output logic [7:0]              cmdData,
  output logic [7:0]              rdData,
  output logic [1:0]              statusCode,
  output logic [LEN_W-1:0]        nackCount
);

  localparam int AW    = 8 * ADDR_BYTES;
  localparam int EXT_W = AW + 8;

  logic [DEV_W-1:0]  devReg;
  logic [AW-1:0]     addrReg;
  logic [ALEN_W-1:0] alenLeft;
  logic [LEN_W-1:0]  lenLeft;
  logic [7:0]        dataReg;
  logic [LEN_W-1:0]  nackCnt;
  status_e           errReg;

  // request-time address shaping
  logic [ALEN_W-1:0] alenC;
  logic [EXT_W-1:0]  extAddr;
  logic [EXT_W-1:0]  upperBits;
  logic [DEV_W-1:0]  devEff;
  logic [AW-1:0]     alignAddr;

  always_comb begin
    alenC     = (int'(reqAlen) > ADDR_BYTES) ? ALEN_W'(ADDR_BYTES) : reqAlen;
    extAddr   = {8'h00, reqAddr};
    upperBits = extAddr >> (8 * int'(alenC));
    devEff    = reqDev | (upperBits[DEV_W-1:0] & cfgOvfMask);
    alignAddr = reqAddr << (8 * (ADDR_BYTES - int'(alenC)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= OP_PROBE;
      repReg   <= 1'b0;
      devReg   <= '0;
      addrReg  <= '0;
      alenLeft <= '0;
      lenLeft  <= '0;
      dataReg  <= '0;
      nackCnt  <= '0;
      errReg   <= ST_OK;
    end else begin
      if (ctl.latchReq) begin
        opReg    <= reqop_e'(reqOp);
        repReg   <= cfgRepStart;
        devReg   <= devEff;
        addrReg  <= alignAddr;
        alenLeft <= alenC;
        lenLeft  <= reqLen;
        nackCnt  <= '0;
        errReg   <= ST_OK;
      end
      if (ctl.shiftAddr) begin
        addrReg  <= addrReg << 8;
        alenLeft <= alenLeft - 1'b1;
      end
      if (ctl.loadWr)  dataReg <= wrData;
      if (ctl.loadRd)  dataReg <= engRxData;
      if (ctl.decLen)  lenLeft <= lenLeft - 1'b1;
      if (ctl.incNack) nackCnt <= nackCnt + 1'b1;
      if (ctl.setErr)  errReg  <= ctl.errCode;
    end
  end

  always_comb begin
    case (ctl.sel)
      SEL_DEVW: cmdData = {devReg, 1'b0};
      SEL_DEVR: cmdData = {devReg, 1'b1};
      SEL_ADDR: cmdData = addrReg[AW-1 -: 8];
      default:  cmdData = dataReg;
    endcase
  end

  assign rdData     = dataReg;
  assign alenZero   = (alenLeft == '0);
  assign alenLast   = (alenLeft == ALEN_W'(1));
  assign lenZero    = (lenLeft == '0);
  assign lenLast    = (lenLeft == LEN_W'(1));
  assign nackCount  = nackCnt;
  assign statusCode = (errReg == ST_OK && nackCnt != '0) ? ST_DATANACK : errReg;

endmodule

// File: rtl/i2c_txn_ctl.sv
module i2c_txn_ctl
  import i2c_txn_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  reqop_e  opReg,
  input  logic    repReg,
  input  logic    alenZero,
  input  logic    alenLast,
  input  logic    lenZero,
  input  logic    lenLast,
  input  logic    wrValid,
  output logic    wrReady,
  output logic    rdValid,
  input  logic    rdReady,
  output logic    cmdValid,
  output buscmd_e cmdOp,
  output logic    cmdNackOut,
  input  logic    engDone,
  input  logic    engNack,
  output logic    done,
  output ctl_t    ctl
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEVW, S_ADDR, S_TSTOP, S_RSTART, S_DEVR,
    S_RDBYTE, S_RDPUSH, S_WRFETCH, S_WRBYTE, S_STOP, S_FIN
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt        = state;
    ctl        = '0;
    reqReady   = 1'b0;
    wrReady    = 1'b0;
    rdValid    = 1'b0;
    cmdValid   = 1'b0;
    cmdOp      = BC_START;
    cmdNackOut = 1'b0;
    done       = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          nxt          = S_START;
        end
      end
      S_START: begin
        cmdValid = 1'b1;
        cmdOp    = BC_START;
        if (engDone) nxt = (opReg == OP_READ && alenZero) ? S_DEVR : S_DEVW;
      end
      S_DEVW: begin
        cmdValid = 1'b1;
        cmdOp    = BC_WRITE;
        ctl.sel  = SEL_DEVW;
        if (engDone) begin
          if (engNack) begin
            ctl.setErr  = 1'b1;
            ctl.errCode = ST_NODEV;
            nxt         = S_STOP;
          end else if (opReg == OP_PROBE) begin
            nxt = S_STOP;
          end else if (!alenZero) begin
            nxt = S_ADDR;
          end else begin
            nxt = lenZero ? S_STOP : S_WRFETCH;
          end
        end
      end
      S_ADDR: begin
        cmdValid = 1'b1;
        cmdOp    = BC_WRITE;
        ctl.sel  = SEL_ADDR;
        if (engDone) begin
          ctl.shiftAddr = 1'b1;
          if (engNack) begin
            ctl.setErr  = 1'b1;
            ctl.errCode = ST_ADDRERR;
            nxt         = S_STOP;
          end else if (alenLast) begin
            if (opReg == OP_READ) nxt = repReg ? S_RSTART : S_TSTOP;
            else                  nxt = lenZero ? S_STOP : S_WRFETCH;
          end
        end
      end
      S_TSTOP: begin
        cmdValid = 1'b1;
        cmdOp    = BC_STOP;
        if (engDone) nxt = S_RSTART;
      end
      S_RSTART: begin
        cmdValid = 1'b1;
        cmdOp    = BC_START;
        if (engDone) nxt = S_DEVR;
      end
      S_DEVR: begin
        cmdValid = 1'b1;
        cmdOp    = BC_WRITE;
        ctl.sel  = SEL_DEVR;
        if (engDone) nxt = lenZero ? S_STOP : S_RDBYTE;
      end
      S_RDBYTE: begin
        cmdValid   = 1'b1;
        cmdOp      = BC_READ;
        cmdNackOut = lenLast;
        if (engDone) begin
          ctl.loadRd = 1'b1;
          nxt        = S_RDPUSH;
        end
      end
      S_RDPUSH: begin
        rdValid = 1'b1;
        if (rdReady) begin
          ctl.decLen = 1'b1;
          nxt        = lenLast ? S_STOP : S_RDBYTE;
        end
      end
      S_WRFETCH: begin
        wrReady = 1'b1;
        if (wrValid) begin
          ctl.loadWr = 1'b1;
          nxt        = S_WRBYTE;
        end
      end
      S_WRBYTE: begin
        cmdValid = 1'b1;
        cmdOp    = BC_WRITE;
        ctl.sel  = SEL_DATA;
        if (engDone) begin
          ctl.decLen  = 1'b1;
          ctl.incNack = engNack;
          nxt         = lenLast ? S_STOP : S_WRFETCH;
        end
      end
      S_STOP: begin
        cmdValid = 1'b1;
        cmdOp    = BC_STOP;
        if (engDone) nxt = S_FIN;
      end
      S_FIN: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_txn_pkg::*;
#(
  parameter int DEV_W      = 7,
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  parameter int ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [1:0]              reqOp,
  input  logic [DEV_W-1:0]        reqDev,
  input  logic [8*ADDR_BYTES-1:0] reqAddr,
  input  logic [ALEN_W-1:0]       reqAlen,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic                    cfgRepStart,
  input  logic [DEV_W-1:0]        cfgOvfMask,
  input  logic [7:0]              wrData,
  input  logic                    wrValid,
  output logic                    wrReady,
  output logic [7:0]              rdData,
  output logic                    rdValid,
  input  logic                    rdReady,
  output logic                    cmdValid,
  output logic [1:0]              cmdOp,
  output logic [7:0]              cmdData,
  output logic                    cmdNackOut,
  input  logic                    engDone,
  input  logic                    engNack,
  input  logic [7:0]              engRxData,
  output logic                    done,
  output logic [1:0]              statusCode,
  output logic [LEN_W-1:0]        nackCount
);

  ctl_t    ctl;
  reqop_e  opReg;
  buscmd_e cmdOpE;
  logic    repReg, alenZero, alenLast, lenZero, lenLast;

  i2c_txn_dp #(
    .DEV_W(DEV_W), .ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .ALEN_W(ALEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqOp(reqOp), .reqDev(reqDev), .reqAddr(reqAddr), .reqAlen(reqAlen),
    .reqLen(reqLen), .cfgRepStart(cfgRepStart), .cfgOvfMask(cfgOvfMask),
    .wrData(wrData), .engRxData(engRxData),
    .opReg(opReg), .repReg(repReg), .alenZero(alenZero), .alenLast(alenLast),
    .lenZero(lenZero), .lenLast(lenLast), .cmdData(cmdData), .rdData(rdData),
    .statusCode(statusCode), .nackCount(nackCount)
  );

  i2c_txn_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .opReg(opReg), .repReg(repReg), .alenZero(alenZero), .alenLast(alenLast),
    .lenZero(lenZero), .lenLast(lenLast), .wrValid(wrValid), .wrReady(wrReady),
    .rdValid(rdValid), .rdReady(rdReady), .cmdValid(cmdValid), .cmdOp(cmdOpE),
    .cmdNackOut(cmdNackOut), .engDone(engDone), .engNack(engNack),
    .done(done), .ctl(ctl)
  );

  assign cmdOp = cmdOpE;

endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic [7:0] cmdData,
  input logic       engDone,
  input logic       rdValid,
  input logic       rdReady,
  input logic [7:0] rdData,
  input logic       wrReady,
  input logic       done
);

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !engDone |=> cmdValid && $stable(cmdOp) && $stable(cmdData));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid || wrReady) |-> !cmdValid);

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdData));

  p_rd_after_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && engDone && cmdOp == 2'd3 |=> rdValid);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_idle_after_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  p_ready_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !cmdValid && !done && !rdValid && !wrReady);

endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (.*);

// File: tb/i2c_txn_seq_test.sv
module i2c_txn_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [6:0]  reqDev = 7'd0;
  logic [31:0] reqAddr = 32'd0;
  logic [2:0]  reqAlen = 3'd0;
  logic [7:0]  reqLen = 8'd0;
  logic        cfgRepStart = 1'b0;
  logic [6:0]  cfgOvfMask = 7'd0;
  logic [7:0]  wrData = 8'd0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        rdReady = 1'b1;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [7:0]  cmdData;
  logic        cmdNackOut;
  logic        engDone = 1'b0;
  logic        engNack = 1'b0;
  logic [7:0]  engRxData = 8'd0;
  logic        done;
  logic [1:0]  statusCode;
  logic [7:0]  nackCount;

  always #5 clk = ~clk;

  i2c_txn_seq uut (.*);

  int total = 0;
  int fails = 0;

  // ---------------- behavioural bit-phase engine ----------------
  logic [1:0] logOp   [0:511];
  logic [7:0] logData [0:511];
  logic       logNk   [0:511];
  int         logN = 0;
  int         eCnt = 0;
  logic       first = 1'b0;
  logic [7:0] rCnt = 8'd0;

  function automatic bit present(input logic [6:0] a);
    return (a >= 7'h50 && a <= 7'h53);
  endfunction
  function automatic bit firstAck(input logic [7:0] b);
    return present(b[7:1]) && !(b[7:1] == 7'h53 && b[0]);
  endfunction
  function automatic bit byteNack(input logic [7:0] b);
    return (b == 8'hEE) || (b[7:4] == 4'hF);
  endfunction

  always @(posedge clk) begin
    engDone <= 1'b0;
    if (!rstN) begin
      eCnt <= 0; logN <= 0; first <= 1'b0; rCnt <= 8'd0;
    end else if (cmdValid && !engDone) begin
      if (eCnt == 2) begin
        eCnt    <= 0;
        engDone <= 1'b1;
        engNack <= 1'b0;
        case (cmdOp)
          2'd0: begin first <= 1'b1; rCnt <= 8'd0; end
          2'd2: begin
            if (first) engNack <= !firstAck(cmdData);
            else       engNack <= byteNack(cmdData);
            first <= 1'b0;
          end
          2'd3: begin engRxData <= 8'hC0 + rCnt; rCnt <= rCnt + 8'd1; end
          default: ;
        endcase
        logOp[logN]   <= cmdOp;
        logData[logN] <= (cmdOp == 2'd2) ? cmdData : 8'd0;
        logNk[logN]   <= (cmdOp == 2'd3) ? cmdNackOut : 1'b0;
        logN          <= logN + 1;
      end else begin
        eCnt <= eCnt + 1;
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input logic [23:0] tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R11 watchdog: actual=no completion expected=completion");
    finishRun();
  end

  // expected command sequence
  logic [1:0] expOp   [0:63];
  logic [7:0] expData [0:63];
  logic       expNk   [0:63];
  int         expN;

  task automatic pushExp(input logic [1:0] op, input logic [7:0] d, input logic nk);
    expOp[expN] = op; expData[expN] = d; expNk[expN] = nk; expN++;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  dev;
    logic [31:0] addr;
    logic [2:0]  alen;
    logic [7:0]  len;
    logic        rep;
    logic [6:0]  mask;
    logic [7:0]  base;
    logic [1:0]  expSt;
    logic [7:0]  expNack;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h50, 32'h0,        3'd0, 8'd0, 1'b0, 7'h00, 8'h00, 2'd0, 8'd0, "R1"},
    '{2'd0, 7'h20, 32'h0,        3'd0, 8'd0, 1'b0, 7'h00, 8'h00, 2'd1, 8'd0, "R1"},
    '{2'd1, 7'h50, 32'h1234,     3'd2, 8'd3, 1'b0, 7'h00, 8'h00, 2'd0, 8'd0, "R2"},
    '{2'd1, 7'h50, 32'h0456,     3'd2, 8'd2, 1'b1, 7'h00, 8'h00, 2'd0, 8'd0, "R5"},
    '{2'd1, 7'h51, 32'h0,        3'd0, 8'd2, 1'b0, 7'h00, 8'h00, 2'd0, 8'd0, "R6"},
    '{2'd2, 7'h50, 32'h10,       3'd1, 8'd4, 1'b0, 7'h00, 8'hD0, 2'd3, 8'd1, "R8"},
    '{2'd2, 7'h50, 32'h12EE,     3'd2, 8'd2, 1'b0, 7'h00, 8'h00, 2'd2, 8'd0, "R4"},
    '{2'd1, 7'h20, 32'h05,       3'd1, 8'd1, 1'b0, 7'h00, 8'h00, 2'd1, 8'd0, "R3"},
    '{2'd1, 7'h50, 32'h2A5,      3'd1, 8'd1, 1'b0, 7'h03, 8'h00, 2'd0, 8'd0, "R9"},
    '{2'd2, 7'h50, 32'h01020304, 3'd4, 8'd1, 1'b0, 7'h7F, 8'h30, 2'd0, 8'd0, "R2"},
    '{2'd2, 7'h50, 32'h0,        3'd0, 8'd2, 1'b0, 7'h00, 8'h05, 2'd0, 8'd0, "R8"},
    '{2'd1, 7'h53, 32'h0,        3'd0, 8'd1, 1'b0, 7'h00, 8'h00, 2'd0, 8'd0, "R7"},
    '{2'd2, 7'h50, 32'h00ABCD,   3'd3, 8'd2, 1'b0, 7'h00, 8'hF5, 2'd3, 8'd1, "R8"},
    '{2'd1, 7'h50, 32'hEE,       3'd1, 8'd1, 1'b0, 7'h00, 8'h00, 2'd2, 8'd0, "R4"}
  };

  task automatic buildExp(input vec_t v);
    logic [39:0] ext;
    logic [6:0]  eff;
    logic [7:0]  b;
    expN = 0;
    ext  = {8'h00, v.addr} >> (8 * int'(v.alen));
    eff  = v.dev | (ext[6:0] & v.mask);
    pushExp(2'd0, 8'd0, 1'b0);
    if (v.op == 2'd0) begin
      pushExp(2'd2, {eff, 1'b0}, 1'b0);
      pushExp(2'd1, 8'd0, 1'b0);
      return;
    end
    if (v.op == 2'd2 || v.alen != 0) begin
      pushExp(2'd2, {eff, 1'b0}, 1'b0);
      if (!present(eff)) begin pushExp(2'd1, 8'd0, 1'b0); return; end
      for (int i = 0; i < int'(v.alen); i++) begin
        b = 8'(v.addr >> (8 * (int'(v.alen) - 1 - i)));
        pushExp(2'd2, b, 1'b0);
        if (byteNack(b)) begin pushExp(2'd1, 8'd0, 1'b0); return; end
      end
    end
    if (v.op == 2'd1) begin
      if (v.alen != 0) begin
        if (!v.rep) pushExp(2'd1, 8'd0, 1'b0);
        pushExp(2'd0, 8'd0, 1'b0);
      end
      pushExp(2'd2, {eff, 1'b1}, 1'b0);
      for (int k = 0; k < int'(v.len); k++)
        pushExp(2'd3, 8'd0, (k == int'(v.len) - 1));
    end else begin
      for (int k = 0; k < int'(v.len); k++)
        pushExp(2'd2, v.base + 8'(k * 8'h11), 1'b0);
    end
    pushExp(2'd1, 8'd0, 1'b0);
  endtask

  task automatic cmpSeq(input int base, input logic [23:0] tag);
    int bad = -1;
    for (int i = 0; i < expN; i++) begin
      if (bad < 0 && (base + i >= logN || logOp[base+i] != expOp[i] ||
          logData[base+i] != expData[i] || logNk[base+i] != expNk[i])) bad = i;
    end
    chk(logN - base == expN, tag, "command count", logN - base, expN);
    if (bad >= 0)
      chk(1'b0, tag, $sformatf("command %0d {op,data,nack}", bad),
          {logOp[base+bad], logData[base+bad], logNk[base+bad]},
          {expOp[bad], expData[bad], expNk[bad]});
    else chk(1'b1, tag, "sequence", 0, 0);
  endtask

  task automatic setReq(input vec_t v);
    reqOp = v.op; reqDev = v.dev; reqAddr = v.addr; reqAlen = v.alen;
    reqLen = v.len; cfgRepStart = v.rep; cfgOvfMask = v.mask;
  endtask

  task automatic runVec(input vec_t v);
    int base = logN;
    int wrIdx = 0;
    int rdIdx = 0;
    bit rdOk = 1'b1;
    int guard = 0;
    buildExp(v);
    @(negedge clk);
    setReq(v);
    reqValid = 1'b1; rdReady = 1'b1; wrValid = 1'b1; wrData = v.base;
    forever begin
      @(negedge clk);
      reqValid = 1'b0;
      if (wrReady) begin wrData = v.base + 8'(wrIdx * 8'h11); wrIdx++; end
      if (rdValid) begin
        if (rdData != 8'hC0 + 8'(rdIdx)) rdOk = 1'b0;
        rdIdx++;
      end
      if (done) break;
      guard++;
      if (guard > 2000) break;
    end
    chk(done, v.tag, "done reached", done, 1);
    chk(statusCode == v.expSt, v.tag, "statusCode", statusCode, v.expSt);
    chk(nackCount == v.expNack, v.tag, "nackCount", nackCount, v.expNack);
    cmpSeq(base, v.tag);
    if (v.op == 2'd1 && v.expSt == 2'd0)
      chk(rdOk && rdIdx == int'(v.len), "R7", "read bytes delivered", rdIdx, v.len);
    @(negedge clk);
    chk(!done && reqReady, "R11", "done one cycle then idle", {done, reqReady}, 2'b01);
  endtask

  initial begin
    vec_t v;
    int base;
    int okCnt;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(reqReady && !cmdValid && !done && !rdValid && !wrReady, "R12", "reset outputs",
        {reqReady, cmdValid, done, rdValid, wrReady}, 5'b10000);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !cmdValid, "R12", "idle after reset", {reqReady, cmdValid}, 2'b10);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R10 read stall: rdReady held low
    v = '{2'd1, 7'h50, 32'h0, 3'd0, 8'd2, 1'b0, 7'h00, 8'h00, 2'd0, 8'd0, "R10"};
    @(negedge clk);
    setReq(v); reqValid = 1'b1; rdReady = 1'b0;
    @(negedge clk); reqValid = 1'b0;
    while (!rdValid) @(negedge clk);
    okCnt = 0;
    for (int c = 0; c < 8; c++) begin
      if (rdValid && !cmdValid && rdData == 8'hC0) okCnt++;
      @(negedge clk);
    end
    chk(okCnt == 8, "R10", "read stall holds bus", okCnt, 8);
    rdReady = 1'b1;
    while (!done) @(negedge clk);
    chk(statusCode == 2'd0, "R10", "read stall status", statusCode, 0);
    @(negedge clk);

    // R10 write stall: wrValid held low
    v = '{2'd2, 7'h50, 32'h0, 3'd0, 8'd1, 1'b0, 7'h00, 8'h22, 2'd0, 8'd0, "R10"};
    base = logN;
    setReq(v); wrValid = 1'b0; reqValid = 1'b1;
    @(negedge clk); reqValid = 1'b0;
    while (!wrReady) @(negedge clk);
    okCnt = 0;
    for (int c = 0; c < 8; c++) begin
      if (wrReady && !cmdValid) okCnt++;
      @(negedge clk);
    end
    chk(okCnt == 8, "R10", "write stall holds bus", okCnt, 8);
    wrData = 8'h22; wrValid = 1'b1;
    while (!done) @(negedge clk);
    chk(logData[base+2] == 8'h22, "R10", "stalled byte written", logData[base+2], 8'h22);
    @(negedge clk);

    // R11 request while busy is ignored
    v = '{2'd0, 7'h50, 32'h0, 3'd0, 8'd0, 1'b0, 7'h00, 8'h00, 2'd0, 8'd0, "R11"};
    base = logN;
    setReq(v); reqValid = 1'b1;
    @(negedge clk);
    reqDev = 7'h20;
    okCnt = 0;
    for (int c = 0; c < 5; c++) begin
      if (!reqReady) okCnt++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(okCnt == 5, "R11", "reqReady low while busy", okCnt, 5);
    while (!done) @(negedge clk);
    chk(statusCode == 2'd0, "R11", "busy request not taken: status", statusCode, 0);
    @(negedge clk);
    repeat (10) @(negedge clk);
    chk(logN - base == 3 && logData[base+1] == 8'hA0, "R11", "only one transaction on bus",
        logN - base, 3);

    finishRun();
  end

endmodule